// File: doc/BRIEF.md
# Byte-Accessed 16-bit Up/Down Timer Counter

This block is a 16-bit timer counter that an 8-bit processor reaches through a narrow register window. The count moves by one on every enabled tick, upward or downward as a direction input selects, and wraps at a programmable ceiling. A shared high-byte holding register makes 16-bit transfers atomic. Reading the low byte captures the live high byte into the holding register in the same cycle. Writing the low byte commits the holding register and the new low byte together.

The tick comes from a small selector. It picks one of five taps of a free-running prescaler, or one edge polarity of an external pin, which is brought in through a two-flop synchronizer and then an edge detector. Selector value zero halts counting, and the processor can still reach the count while it is halted. A direction input and a clear input come from a mode-control stage outside the block. The block reports at-ceiling and at-zero flags, a one-cycle overflow pulse, and a sticky overflow flag.

Top module: `bus_timer16`

## Requirements
- R1: On each tick the count rises by one when `dir_down` is 0 and falls by one when `dir_down` is 1.
- R2: Bus address 0 reads count bits 7:0. Address 1 reads the holding register. Address 2 reads the overflow flag in bit 0, with the other bits zero. Address 3 reads zero.
- R3: A read at address 0 latches count bits 15:8 into the holding register at that clock edge. The holding register keeps its value at every other time. A later read at address 1 returns the latched byte and not the live high byte.
- R4: A write at address 1 loads only the holding register. A write at address 0 loads the count with {holding register, write data} at that edge.
- R5: With `clk_sel` = 0 the count holds its value. Bus reads and writes of the count still work while it is held.
- R6: A count write through address 0 takes priority over `clr` and over a tick in the same cycle.
- R7: `clr` sets the count to zero, and it wins over a tick in the same cycle.
- R8: `at_bottom` is high exactly when the count is 0. `at_top` is high exactly when the count equals `top_val`.
- R9: An up tick with the count at `top_val` or at 0xFFFF gives 0. A down tick with the count at 0 gives `top_val`.
- R10: `clk_sel` values 1 to 5 tick at divide-by 1, 8, 64, 256 and 1024. A tick falls in each cycle in which the number of clock edges since reset release, taken modulo the divisor, equals the divisor minus one.
- R11: `clk_sel` 6 counts falling edges of `ext_in` and `clk_sel` 7 counts rising edges. Each edge counts once, no more than three cycles after it occurs.
- R12: An up tick that wraps to zero raises `ovf_pulse` for one cycle and sets `ovf_flag` (address 2 bit 0). Writing 1 to address 2 bit 0 clears the flag, and writing 0 to it has no effect. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Tick source select |
| ext_in | input | 1 | External event pin, asynchronous |
| dir_down | input | 1 | Count direction, 1 = down |
| clr | input | 1 | Synchronous count clear |
| top_val | input | 16 | Count ceiling |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Bus read data, combinational |
| at_top | output | 1 | Count equals top_val |
| at_bottom | output | 1 | Count equals zero |
| ovf_pulse | output | 1 | One-cycle overflow request |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle, and that the bus control and data inputs settle before each clock edge. The stimulus meets both assumptions by driving every bus strobe for exactly one cycle, from the falling clock edge. It changes `clk_sel`, `clr` and `ext_in` only at falling edges, and it keeps `ext_in` quiet whenever the selector moves. The sweep writes start values at, below and above the ceiling under a full ceiling and under a small one, so that the wrap and step properties see their boundary inputs.

// File: rtl/tctr_pkg.sv
package tctr_pkg;

   typedef enum logic [2:0] {
      CS_OFF      = 3'd0,
      CS_DIV1     = 3'd1,
      CS_DIV8     = 3'd2,
      CS_DIV64    = 3'd3,
      CS_DIV256   = 3'd4,
      CS_DIV1024  = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } csel_e;

   typedef enum logic [1:0] {
      RA_CNT_LO = 2'd0,
      RA_CNT_HI = 2'd1,
      RA_FLAGS  = 2'd2,
      RA_SPARE  = 2'd3
   } regaddr_e;

   localparam int N_TAPS = 5;
   localparam int MAX_TAP_LOG2 = 10;

   function automatic int tap_log2(input int idx);
      case (idx)
         0:       tap_log2 = 0;
         1:       tap_log2 = 3;
         2:       tap_log2 = 6;
         3:       tap_log2 = 8;
         default: tap_log2 = 10;
      endcase
   endfunction

endpackage

// File: rtl/tctr_tick_sel.sv
module tctr_tick_sel
   import tctr_pkg::*;
#(
   parameter int PSC_W  = 10,
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] clk_sel,
   input  logic       ext_in,
   output logic       tick
);

   localparam int SH_W = SYNC_N + 1;

   if (PSC_W < MAX_TAP_LOG2) begin : g_bad_psc
      $error("tctr_tick_sel: PSC_W too small for the largest divider");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("tctr_tick_sel: SYNC_N must be at least 2");
   end

   logic [PSC_W-1:0]  psc_q;
   logic [N_TAPS-1:0] tap_hit;
   logic [SH_W-1:0]   sh_q;
   logic              ext_rise, ext_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psc_q <= '0;
      else        psc_q <= psc_q + 1'b1;
   end

   for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
      localparam int L = tap_log2(i);
      if (L == 0) begin : g_every
         assign tap_hit[i] = 1'b1;
      end else begin : g_div
         assign tap_hit[i] = &psc_q[L-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SH_W-2:0], ext_in};
   end

   assign ext_rise =  sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
   assign ext_fall = ~sh_q[SYNC_N-1] &  sh_q[SYNC_N];

   always_comb begin
      case (csel_e'(clk_sel))
         CS_DIV1:     tick = tap_hit[0];
         CS_DIV8:     tick = tap_hit[1];
         CS_DIV64:    tick = tap_hit[2];
         CS_DIV256:   tick = tap_hit[3];
         CS_DIV1024:  tick = tap_hit[4];
         CS_EXT_FALL: tick = ext_fall;
         CS_EXT_RISE: tick = ext_rise;
         default:     tick = 1'b0;
      endcase
   end

   // R5
   off_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0) |-> !tick);

   // R11
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise |=> !ext_rise);

endmodule

// File: rtl/tctr_core.sv
module tctr_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             dir_down,
   input  logic             clr,
   input  logic [CNT_W-1:0] top_val,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_val,
   output logic [CNT_W-1:0] cnt,
   output logic             at_top,
   output logic             at_bottom,
   output logic             wrap_evt,
   output logic             ovf_pulse
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_w
      $error("tctr_core: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             step, up_wrap, dn_wrap;

   assign at_top    = (cnt_q == top_val);
   assign at_bottom = (cnt_q == '0);
   assign step      = tick & ~clr & ~wr_en;
   assign up_wrap   = at_top | (cnt_q == ALL_ONES);
   assign dn_wrap   = at_bottom;
   assign wrap_evt  = step & ~dir_down & up_wrap;

   always_comb begin
      cnt_d = cnt_q;
      if (wr_en) begin
         cnt_d = wr_val;
      end else if (clr) begin
         cnt_d = '0;
      end else if (tick) begin
         if (dir_down) cnt_d = dn_wrap ? top_val : cnt_q - ONE;
         else          cnt_d = up_wrap ? '0 : cnt_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         cnt_q     <= cnt_d;
         ovf_pulse <= wrap_evt;
      end
   end

   assign cnt = cnt_q;

   // R6
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cnt_q == $past(wr_val));

   // R7
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> cnt_q == '0);

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr && !wr_en) |=> $stable(cnt_q));

   // R1
   up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !dir_down && !up_wrap) |=> cnt_q == $past(cnt_q) + ONE);

   // R1
   dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dir_down && !dn_wrap) |=> cnt_q == $past(cnt_q) - ONE);

   // R9
   dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && dir_down && dn_wrap) |=> cnt_q == $past(top_val));

   // R12
   ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> cnt_q == '0);

endmodule

// File: rtl/tctr_busif.sv
module tctr_busif
   import tctr_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic             wrap_evt,
   output logic             cnt_wr_en,
   output logic [CNT_W-1:0] cnt_wr_val,
   output logic             ovf_flag
);

   if (CNT_W != 2 * BUS_W) begin : g_bad_split
      $error("tctr_busif: CNT_W must be twice BUS_W");
   end

   logic [BUS_W-1:0] hold_q;
   logic             rd_lo, wr_hi, wr_flags, flag_clr;

   assign rd_lo    = bus_rd & (bus_addr == RA_CNT_LO);
   assign wr_hi    = bus_wr & (bus_addr == RA_CNT_HI);
   assign wr_flags = bus_wr & (bus_addr == RA_FLAGS);
   assign flag_clr = wr_flags & bus_wdata[0];

   assign cnt_wr_en  = bus_wr & (bus_addr == RA_CNT_LO);
   assign cnt_wr_val = {hold_q, bus_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= '0;
      else if (rd_lo) hold_q <= cnt[CNT_W-1:BUS_W];
      else if (wr_hi) hold_q <= bus_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf_flag <= 1'b0;
      else if (wrap_evt) ovf_flag <= 1'b1;
      else if (flag_clr) ovf_flag <= 1'b0;
   end

   always_comb begin
      case (regaddr_e'(bus_addr))
         RA_CNT_LO: bus_rdata = cnt[BUS_W-1:0];
         RA_CNT_HI: bus_rdata = hold_q;
         RA_FLAGS:  bus_rdata = {{(BUS_W-1){1'b0}}, ovf_flag};
         default:   bus_rdata = '0;
      endcase
   end

   // R3
   lo_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> hold_q == $past(cnt[CNT_W-1:BUS_W]));

   // R4
   hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && !bus_rd) |=> hold_q == $past(bus_wdata));

   // R3
   hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_lo && !wr_hi) |=> $stable(hold_q));

   // R12
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_evt |=> ovf_flag);

   // R12
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !wrap_evt) |=> !ovf_flag);

endmodule

// File: rtl/bus_timer16.sv
module bus_timer16 #(
   parameter int BUS_W  = 8,
   parameter int CNT_W  = 16,
   parameter int PSC_W  = 10,
   parameter int SYNC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       clk_sel,
   input  logic             ext_in,
   input  logic             dir_down,
   input  logic             clr,
   input  logic [CNT_W-1:0] top_val,
   input  logic             bus_rd,
   input  logic             bus_wr,
   input  logic [1:0]       bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             at_top,
   output logic             at_bottom,
   output logic             ovf_pulse,
   output logic             ovf_flag
);

   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             wrap_evt;
   logic             cnt_wr_en;
   logic [CNT_W-1:0] cnt_wr_val;

   tctr_tick_sel #(.PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .ext_in  (ext_in),
      .tick    (tick)
   );

   tctr_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .dir_down  (dir_down),
      .clr       (clr),
      .top_val   (top_val),
      .wr_en     (cnt_wr_en),
      .wr_val    (cnt_wr_val),
      .cnt       (cnt),
      .at_top    (at_top),
      .at_bottom (at_bottom),
      .wrap_evt  (wrap_evt),
      .ovf_pulse (ovf_pulse)
   );

   tctr_busif #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_rd     (bus_rd),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .cnt        (cnt),
      .wrap_evt   (wrap_evt),
      .cnt_wr_en  (cnt_wr_en),
      .cnt_wr_val (cnt_wr_val),
      .ovf_flag   (ovf_flag)
   );

   // R2
   bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_wr));

endmodule

// File: tb/bus_timer16_test.sv
`timescale 1ns/1ps
module bus_timer16_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  clk_sel = 3'd0;
   logic        ext_in = 1'b0;
   logic        dir_down = 1'b0;
   logic        clr = 1'b0;
   logic [15:0] top_val = 16'hFFFF;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [7:0]  bus_rdata;
   logic        at_top, at_bottom, ovf_pulse, ovf_flag;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int exp_pulses = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bus_timer16 uut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ext_in(ext_in),
      .dir_down(dir_down), .clr(clr), .top_val(top_val),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .at_top(at_top),
      .at_bottom(at_bottom), .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag)
   );

   always @(posedge clk or negedge rst_n)
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;

   always @(negedge clk)
      if (rst_n && ovf_pulse) pulses++;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [1:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic set_cnt(input logic [15:0] v);
      bwr(2'd1, v[15:8]);
      bwr(2'd0, v[7:0]);
   endtask

   task automatic get_cnt(output logic [15:0] v);
      logic [7:0] lo, hi;
      brd(2'd0, lo);
      brd(2'd1, hi);
      v = {hi, lo};
   endtask

   task automatic run(input logic [2:0] sel, input int n);
      clk_sel = sel;
      repeat (n) @(negedge clk);
      clk_sel = 3'd0;
   endtask

   function automatic logic [15:0] nxt(input logic [15:0] c, input logic dn, input logic [15:0] t);
      if (!dn) nxt = (c == t || c == 16'hFFFF) ? 16'h0000 : c + 16'd1;
      else     nxt = (c == 16'h0000) ? t : c - 16'd1;
   endfunction

   initial begin
      #(4 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, e;
      logic [7:0]  b;
      logic [15:0] starts [6];
      starts = '{16'h0000, 16'h0001, 16'h00FE, 16'h7FFF, 16'hFFFE, 16'hFFFF};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      get_cnt(v);
      chk("R2 reset count", v, 16'h0000);
      chk("R8 reset bottom", {15'd0, at_bottom}, 16'd1);
      chk("R12 reset flag", {15'd0, ovf_flag}, 16'd0);
      brd(2'd3, b);
      chk("R2 spare addr", {8'd0, b}, 16'd0);

      // R1 R9 sweep with full ceiling
      top_val = 16'hFFFF;
      for (int s = 0; s < 6; s++) begin
         for (int d = 0; d < 2; d++) begin
            for (int n = 1; n <= 5; n += 2) begin
               dir_down = d[0];
               set_cnt(starts[s]);
               e = starts[s];
               for (int k = 0; k < n; k++) begin
                  if (!dir_down && (e == top_val || e == 16'hFFFF)) exp_pulses++;
                  e = nxt(e, dir_down, top_val);
               end
               run(3'd1, n);
               get_cnt(v);
               chk("R1 R9 full sweep", v, e);
            end
         end
      end

      // R9 sweep with small ceiling
      top_val = 16'd7;
      for (int s = 0; s < 10; s++) begin
         for (int d = 0; d < 2; d++) begin
            dir_down = d[0];
            set_cnt(s[15:0]);
            chk("R8 at_top", {15'd0, at_top}, {15'd0, (s == 7)});
            chk("R8 at_bottom", {15'd0, at_bottom}, {15'd0, (s == 0)});
            e = s[15:0];
            for (int k = 0; k < 9; k++) begin
               if (!dir_down && (e == top_val || e == 16'hFFFF)) exp_pulses++;
               e = nxt(e, dir_down, top_val);
            end
            run(3'd1, 9);
            get_cnt(v);
            chk("R9 small ceiling", v, e);
         end
      end
      top_val = 16'hFFFF;
      dir_down = 1'b0;

      // R3 holding register keeps latched byte
      set_cnt(16'h12FE);
      brd(2'd0, b);
      chk("R3 low read", {8'd0, b}, 16'h00FE);
      run(3'd1, 4);
      brd(2'd1, b);
      chk("R3 held high", {8'd0, b}, 16'h0012);
      get_cnt(v);
      chk("R3 live count", v, 16'h1302);

      // R4 high write only touches holding register
      set_cnt(16'h4455);
      bwr(2'd1, 8'hAB);
      brd(2'd1, b);
      chk("R4 hold loaded", {8'd0, b}, 16'h00AB);
      bwr(2'd0, 8'hCD);
      get_cnt(v);
      chk("R4 commit", v, 16'hABCD);

      // R5 stopped
      set_cnt(16'h0100);
      repeat (20) @(negedge clk);
      get_cnt(v);
      chk("R5 held while off", v, 16'h0100);

      // R6 write beats clear and tick
      bwr(2'd1, 8'h5A);
      clk_sel = 3'd1; clr = 1'b1;
      bwr(2'd0, 8'hA5);
      clk_sel = 3'd0; clr = 1'b0;
      get_cnt(v);
      chk("R6 write priority", v, 16'h5AA5);

      // R7 clear beats tick
      clk_sel = 3'd1; clr = 1'b1;
      @(negedge clk);
      clk_sel = 3'd0; clr = 1'b0;
      get_cnt(v);
      chk("R7 clear", v, 16'h0000);

      // R10 prescaler taps
      for (int t = 1; t <= 5; t++) begin
         int dv, n, ex;
         dv = (t == 1) ? 1 : (t == 2) ? 8 : (t == 3) ? 64 : (t == 4) ? 256 : 1024;
         n = dv * 2 + 37;
         ex = 0;
         set_cnt(16'h0000);
         clk_sel = t[2:0];
         for (int i = 0; i < n; i++) begin
            if ((cyc % dv) == dv - 1) ex++;
            @(negedge clk);
         end
         clk_sel = 3'd0;
         get_cnt(v);
         chk("R10 prescale", v, ex[15:0]);
      end

      // R11 external edges
      for (int p = 0; p < 2; p++) begin
         set_cnt(16'h0000);
         ext_in = 1'b0;
         repeat (4) @(negedge clk);
         clk_sel = (p == 0) ? 3'd7 : 3'd6;
         for (int i = 0; i < 5; i++) begin
            ext_in = 1'b1;
            repeat (3) @(negedge clk);
            ext_in = 1'b0;
            repeat (3) @(negedge clk);
         end
         repeat (4) @(negedge clk);
         clk_sel = 3'd0;
         get_cnt(v);
         chk("R11 ext edges", v, 16'd5);
      end

      // R12 sticky flag
      bwr(2'd2, 8'h01);
      brd(2'd2, b);
      chk("R12 flag cleared", {8'd0, b}, 16'd0);
      set_cnt(16'hFFFF);
      exp_pulses++;
      run(3'd1, 1);
      chk("R12 pulse follows wrap", {15'd0, ovf_pulse}, 16'd1);
      @(negedge clk);
      chk("R12 pulse one cycle", {15'd0, ovf_pulse}, 16'd0);
      brd(2'd2, b);
      chk("R12 flag set", {8'd0, b}, 16'd1);
      bwr(2'd2, 8'hFE);
      brd(2'd2, b);
      chk("R12 write zero ignored", {8'd0, b}, 16'd1);
      bwr(2'd2, 8'h01);
      chk("R12 flag write one", {15'd0, ovf_flag}, 16'd0);
      @(negedge clk);
      chk("R12 pulse total", pulses[15:0], exp_pulses[15:0]);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule